// File: doc/BRIEF.md
# Indexed-Absolute Add-With-Carry Sequencer

This block is the multi-cycle control and datapath slice of an 8-bit little-endian processor that runs one instruction: add memory to the accumulator with carry, where the memory address is a 16-bit absolute address plus the 8-bit index register. It fetches the opcode, then the low and high address bytes. It forms the effective address one byte at a time on a single shared 8-bit adder, then reads the operand. The same adder later performs the accumulator sum, in the cycle that already fetches the next opcode.

Every datapath action comes from the registered phase, so the work of a cycle is fixed at the edge before it. Adding the index to the low address byte may carry into the high byte. In that case the first operand read uses the uncorrected page, and one more read cycle repeats the access at the corrected address. The instruction therefore takes four clocks without a page crossing and five with one. Memory is read combinationally: the read data belongs to the address driven in the same cycle.

A synchronous reset loads the program counter, accumulator, index and carry from input pins. An opcode other than the supported one sends the sequencer back to opcode fetch after its first address-byte cycle, and the accumulator and carry are left untouched.

Top module: `idxadd_seq`

## Requirements
- R1: A synchronous active-high reset sets phase_o to 0 (fetch), pc_o to rst_pc, acc_o to init_acc, carry_o to init_carry and the index register to init_idx.
- R2: In the fetch phase (phase_o = 0) mem_addr equals pc_o. At the clock edge, ir_o takes mem_rdata and pc_o advances by one, wrapping from 0xFFFF to 0x0000.
- R3: The two cycles after an opcode fetch have phase_o = 1 and 2. They read the bytes at opcode address +1 (low address byte) and +2 (high address byte), and pc_o advances by one in each.
- R4: The first operand read (phase_o = 3) drives mem_addr = {high byte, (low byte + index) mod 256} and holds pc_o.
- R5: When the low byte plus the index does not exceed 255, the next fetch follows the first operand read, so the opcode fetch to the next fetch takes 4 clocks.
- R6: When the low byte plus the index exceeds 255, an extra read (phase_o = 4) drives mem_addr = {(high byte + 1) mod 256, low byte + index}, with pc_o held. The opcode fetch to the next fetch takes 5 clocks, and a full address of 0xFFFF plus a nonzero index wraps into page 0x00.
- R7: At the end of the fetch that follows the supported instruction, acc_o becomes the low 8 bits of acc + operand + carry, and carry_o becomes the ninth bit. The operand is the byte read in the last operand-read cycle.
- R8: The supported opcode is 0x7D (parameter). For any other opcode, the phase returns to 0 right after phase 1, with pc_o at opcode address +2. acc_o and carry_o keep their values through the following fetch.
- R9: acc_o and carry_o change only at the edge that ends a fetch phase, and phase_o never holds a value above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_pc | input | 16 | Program counter value loaded at reset |
| init_acc | input | 8 | Accumulator value loaded at reset |
| init_idx | input | 8 | Index register value loaded at reset |
| init_carry | input | 1 | Carry flag value loaded at reset |
| mem_rdata | input | 8 | Combinational read data for mem_addr |
| mem_addr | output | 16 | Read address |
| pc_o | output | 16 | Program counter |
| ir_o | output | 8 | Instruction register |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry flag |
| phase_o | output | 3 | Phase: 0 fetch, 1 low byte, 2 high byte, 3 read, 4 corrected read |

## Verification
The instruction is run with index values that keep the low-byte sum inside the page and with values that carry out of it. The first kind must give a 4-clock sequence, and the second must give the extra corrected read and 5 clocks. Address corner cases separate a correct high-byte fix-up from a missing one: a base of 0xFFFF with a nonzero index that wraps to page 0x00, and an index of zero. A program placed at 0xFFFE makes the fetch incrementer wrap through the operand bytes. Carry-in of 1 with an accumulator of 0xFF shows whether the final sum uses the carry flag. Random non-supported opcodes confirm the early return and the unchanged accumulator.

// File: rtl/idxadd_pkg.sv
package idxadd_pkg;
    parameter int unsigned DW = 8;
    localparam int unsigned AW = 2 * DW;

    typedef enum logic [2:0] {
        PH_FETCH = 3'd0,
        PH_ALO   = 3'd1,
        PH_AHI   = 3'd2,
        PH_READ  = 3'd3,
        PH_FIX   = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e          ph;
        logic [AW-1:0]   pc;
        logic [DW-1:0]   ir;
        logic [DW-1:0]   acc;
        logic [DW-1:0]   idx;
        logic [DW-1:0]   tl;
        logic [DW-1:0]   th;
        logic [DW-1:0]   data;
        logic            carry;
        logic            flag;
        logic            pend;
    } seq_st_t;
endpackage

// File: rtl/idxadd_alu.sv
module idxadd_alu #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] r_o,
    output logic         co_o
);
    logic [W:0] sum;
    always_comb begin
        sum  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
        r_o  = sum[W-1:0];
        co_o = sum[W];
    end
endmodule

// File: rtl/idxadd_pcinc.sv
module idxadd_pcinc #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] pc_o
);
    always_comb pc_o = pc_i + {{(W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/idxadd_route.sv
module idxadd_route
    import idxadd_pkg::*;
(
    input  phase_e        ph_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] tl_i,
    input  logic [DW-1:0] th_i,
    input  logic [DW-1:0] idx_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] data_i,
    input  logic          carry_i,
    input  logic          flag_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] a_o,
    output logic [DW-1:0] b_o,
    output logic          ci_o
);
    always_comb begin
        addr_o = pc_i;
        a_o    = '0;
        b_o    = '0;
        ci_o   = 1'b0;
        unique case (ph_i)
            PH_FETCH: begin
                a_o  = acc_i;
                b_o  = data_i;
                ci_o = carry_i;
            end
            PH_AHI: begin
                a_o = tl_i;
                b_o = idx_i;
            end
            PH_READ: begin
                addr_o = {th_i, tl_i};
                a_o    = th_i;
                ci_o   = flag_i;
            end
            PH_FIX: begin
                addr_o = {th_i, tl_i};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/idxadd_seq.sv
module idxadd_seq
    import idxadd_pkg::*;
#(
    parameter logic [DW-1:0] OPC = 8'h7D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rst_pc,
    input  logic [DW-1:0] init_acc,
    input  logic [DW-1:0] init_idx,
    input  logic          init_carry,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] ir_o,
    output logic [DW-1:0] acc_o,
    output logic          carry_o,
    output logic [2:0]    phase_o
);
    seq_st_t       st_d, st_q;
    logic [AW-1:0] pc_inc;
    logic [DW-1:0] alu_a, alu_b, alu_r;
    logic          alu_ci, alu_co;
    logic          fix_flag_q;

    idxadd_pcinc #(.W(AW)) u_pcinc (
        .pc_i (st_q.pc),
        .pc_o (pc_inc)
    );

    idxadd_route u_route (
        .ph_i    (st_q.ph),
        .pc_i    (st_q.pc),
        .tl_i    (st_q.tl),
        .th_i    (st_q.th),
        .idx_i   (st_q.idx),
        .acc_i   (st_q.acc),
        .data_i  (st_q.data),
        .carry_i (st_q.carry),
        .flag_i  (st_q.flag),
        .addr_o  (mem_addr),
        .a_o     (alu_a),
        .b_o     (alu_b),
        .ci_o    (alu_ci)
    );

    idxadd_alu #(.W(DW)) u_alu (
        .a_i  (alu_a),
        .b_i  (alu_b),
        .ci_i (alu_ci),
        .r_o  (alu_r),
        .co_o (alu_co)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_FETCH: begin
                st_d.ir = mem_rdata;
                st_d.pc = pc_inc;
                if (st_q.pend) begin
                    st_d.acc   = alu_r;
                    st_d.carry = alu_co;
                end
                st_d.pend = 1'b0;
                st_d.ph   = PH_ALO;
            end
            PH_ALO: begin
                st_d.tl = mem_rdata;
                st_d.pc = pc_inc;
                st_d.ph = (st_q.ir == OPC) ? PH_AHI : PH_FETCH;
            end
            PH_AHI: begin
                st_d.th   = mem_rdata;
                st_d.tl   = alu_r;
                st_d.flag = alu_co;
                st_d.pc   = pc_inc;
                st_d.ph   = PH_READ;
            end
            PH_READ: begin
                st_d.data = mem_rdata;
                st_d.th   = alu_r;
                if (st_q.flag) begin
                    st_d.ph = PH_FIX;
                end else begin
                    st_d.ph   = PH_FETCH;
                    st_d.pend = 1'b1;
                end
            end
            PH_FIX: begin
                st_d.data = mem_rdata;
                st_d.ph   = PH_FETCH;
                st_d.pend = 1'b1;
            end
            default: st_d.ph = PH_FETCH;
        endcase

        if (rst) begin
            st_d.ph    = PH_FETCH;
            st_d.pc    = rst_pc;
            st_d.ir    = '0;
            st_d.acc   = init_acc;
            st_d.idx   = init_idx;
            st_d.tl    = '0;
            st_d.th    = '0;
            st_d.data  = '0;
            st_d.carry = init_carry;
            st_d.flag  = 1'b0;
            st_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign ir_o       = st_q.ir;
    assign acc_o      = st_q.acc;
    assign carry_o    = st_q.carry;
    assign phase_o    = st_q.ph;
    assign fix_flag_q = st_q.flag;
endmodule

// File: rtl/idxadd_seq_chk.sv
module idxadd_seq_chk
    import idxadd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [2:0]    phase,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] acc,
    input logic          carry,
    input logic          flag
);
    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0) |-> (mem_addr == pc));

    // R2
    fetch_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0) |=> (pc == $past(pc) + 16'd1));

    // R4
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3) |=> (pc == $past(pc)));

    // R5
    read_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3 && !flag) |=> (phase == 3'd0));

    // R6
    fix_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3 && flag) |=> (phase == 3'd4));

    // R6
    fix_page_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4) |-> (mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW]) + 8'd1));

    // R6
    fix_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4) |=> (phase == 3'd0 && pc == $past(pc)));

    // R9
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd0) |=> ($stable(acc) && $stable(carry)));

    // R9
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        (phase <= 3'd4));
endmodule

bind idxadd_seq idxadd_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase_o),
    .pc       (pc_o),
    .mem_addr (mem_addr),
    .acc      (acc_o),
    .carry    (carry_o),
    .flag     (fix_flag_q)
);

// File: tb/idxadd_seq_test.sv
`timescale 1ns/1ps
module idxadd_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rst_pc = 16'h0000;
    logic [7:0]  init_acc = 8'h00;
    logic [7:0]  init_idx = 8'h00;
    logic        init_carry = 1'b0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pc_o;
    logic [7:0]  ir_o, acc_o;
    logic        carry_o;
    logic [2:0]  phase_o;

    logic [15:0] prog_pc = 16'h0000;
    logic [7:0]  prog_op = 8'h00, prog_lo = 8'h00, prog_hi = 8'h00;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a, input logic [15:0] p,
                                            input logic [7:0] op, input logic [7:0] lo,
                                            input logic [7:0] hi);
        if (a == p) return op;
        if (a == p + 16'd1) return lo;
        if (a == p + 16'd2) return hi;
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata = mem_byte(mem_addr, prog_pc, prog_op, prog_lo, prog_hi);

    idxadd_seq uut (
        .clk(clk), .rst(rst), .rst_pc(rst_pc), .init_acc(init_acc),
        .init_idx(init_idx), .init_carry(init_carry), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .pc_o(pc_o), .ir_o(ir_o), .acc_o(acc_o),
        .carry_o(carry_o), .phase_o(phase_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input logic [15:0] start, input logic [7:0] op,
                           input logic [7:0] lo, input logic [7:0] hi,
                           input logic [7:0] x, input logic [7:0] a, input logic c);
        logic [15:0] log_a [0:8];
        int n;
        logic [8:0] low_sum;
        logic [15:0] ea, first_rd;
        logic [8:0] sum;
        logic [7:0] oper;
        bit supported;
        prog_pc = start; prog_op = op; prog_lo = lo; prog_hi = hi;
        rst_pc = start; init_acc = a; init_idx = x; init_carry = c;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(phase_o == 3'd0, "R1", "phase", phase_o, 0);
        chk(pc_o == start, "R1", "pc", pc_o, start);
        chk(acc_o == a && carry_o == c, "R1", "acc/carry", {acc_o, carry_o}, {a, c});
        chk(mem_addr == start, "R2", "fetch addr", mem_addr, start);
        log_a[0] = mem_addr;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            log_a[n] = mem_addr;
        end while (phase_o != 3'd0 && n < 8);
        supported = (op == 8'h7D);
        low_sum   = {1'b0, lo} + {1'b0, x};
        ea        = {hi, lo} + {8'h00, x};
        first_rd  = {hi, low_sum[7:0]};
        oper      = mem_byte(low_sum[8] ? ea : first_rd, start, op, lo, hi);
        sum       = {1'b0, a} + {1'b0, oper} + {8'h00, c};
        if (supported) begin
            chk(log_a[1] == start + 16'd1, "R3", "low byte addr", log_a[1], start + 16'd1);
            chk(log_a[2] == start + 16'd2, "R3", "high byte addr", log_a[2], start + 16'd2);
            chk(log_a[3] == first_rd, "R4", "first read addr", log_a[3], first_rd);
            if (low_sum[8]) begin
                // R6 page crossing
                chk(n == 5, "R6", "clocks", n, 5);
                chk(log_a[4] == ea, "R6", "fixed addr", log_a[4], ea);
            end else begin
                // R5 same page
                chk(n == 4, "R5", "clocks", n, 4);
            end
            chk(pc_o == start + 16'd3, "R3", "pc at next fetch", pc_o, start + 16'd3);
            chk(mem_addr == start + 16'd3, "R2", "next fetch addr", mem_addr, start + 16'd3);
            @(negedge clk);
            chk(acc_o == sum[7:0], "R7", "acc", acc_o, sum[7:0]);
            chk(carry_o == sum[8], "R7", "carry", carry_o, sum[8]);
            chk(ir_o == mem_byte(start + 16'd3, start, op, lo, hi), "R2", "ir",
                ir_o, mem_byte(start + 16'd3, start, op, lo, hi));
            chk(pc_o == start + 16'd4, "R2", "pc after fetch", pc_o, start + 16'd4);
        end else begin
            // R8 unsupported opcode
            chk(n == 2, "R8", "clocks", n, 2);
            chk(pc_o == start + 16'd2, "R8", "pc", pc_o, start + 16'd2);
            @(negedge clk);
            chk(acc_o == a && carry_o == c, "R8", "acc/carry kept", {acc_o, carry_o}, {a, c});
        end
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (2) @(negedge clk);
        run_one(16'h0200, 8'h7D, 8'h10, 8'h30, 8'h05, 8'h12, 1'b0);
        run_one(16'h0300, 8'h7D, 8'hF0, 8'h40, 8'h20, 8'h7F, 1'b1);
        run_one(16'h0400, 8'h7D, 8'hFF, 8'hFF, 8'h01, 8'h01, 1'b0);
        run_one(16'h0500, 8'h7D, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b1);
        run_one(16'h0600, 8'h7D, 8'hFF, 8'h22, 8'h00, 8'h80, 1'b0);
        run_one(16'hFFFE, 8'h7D, 8'h80, 8'h12, 8'h80, 8'hFF, 1'b1);
        run_one(16'h0700, 8'h7D, 8'h00, 8'h05, 8'hFF, 8'h00, 1'b0);
        run_one(16'h0800, 8'hEA, 8'h11, 8'h22, 8'h33, 8'h44, 1'b1);
        for (int i = 0; i < 80; i++) begin
            logic [7:0] op;
            op = ($urandom % 5 == 0) ? 8'($urandom) : 8'h7D;
            run_one(16'($urandom), op, 8'($urandom), 8'($urandom), 8'($urandom),
                    8'($urandom), 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule